// File: doc/BRIEF.md
# Dual-Pulse Presettable Up/Down Counter

This block is a 4-bit binary counter steered by two separate active-low count inputs, one that counts up and one that counts down, in place of a direction pin. The count moves by one when the pulsed input returns high while the other input is held high. All state bits are registered in one system clock domain and change together on a single clock edge. The count inputs are edge-detected against that clock, so the external count pulses must each stay low for at least one clock edge.

An active-high clear forces the count to zero at once, without waiting for a clock edge. An active-low load copies four preset bits into the count. A terminal-count output for each direction goes low for exactly as long as the count input of that direction is low, but only while the count sits at its wrap point: 15 going up, 0 going down. Feeding one stage's up terminal into the next stage's up input, and its down terminal into the next stage's down input, builds a wider counter with no extra logic. Presetting a start value turns the counter into a modulo-N divider.

Top module: `updown_pulse_counter`

## Requirements
- R1: Out of reset the count is 0 and both terminal outputs are high. With no count edge, load high and clear low, the count holds its value.
- R2: A low-to-high transition on `up_ni` raises the count by one, and one on `dn_ni` lowers it by one, both modulo 16 (15 up gives 0, 0 down gives 15). The new value appears after the first clock edge that follows the transition.
- R3: While `clear_i` is 1 the count is 0. It drops to 0 before the next clock edge and stays there whatever `load_ni`, `data_i` and the count inputs do.
- R4: When `load_ni` is 0 and clear is low, the count takes `data_i` at the next clock edge. Every value 0 to 15 can be loaded.
- R5: `up_term_no` is 0 only while the count is 15 and `up_ni` is 0. It is therefore low for exactly as many clock cycles as the up pulse at 15, and it returns high when `up_ni` rises.
- R6: `dn_term_no` is 0 only while the count is 0 and `dn_ni` is 0. It is low for exactly as many cycles as the down pulse at 0.
- R7: A count edge that arrives while `load_ni` is 0 is discarded. After load is released, the count equals the loaded data.
- R8: If both count inputs rise in the same clock cycle, the count does not change.
- R9: In a two-stage chain, where the second stage's `up_ni` is driven by the first stage's `up_term_no` and its `dn_ni` by the first stage's `dn_term_no`, the pair counts as one 8-bit value {second, first}. The second stage moves exactly once for each wrap of the first, in both directions.
- R10: After a preset value p is loaded, the up terminal pulse comes on the (16 - p)th up pulse, so the counter divides the pulse rate by 16 - p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; count inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Asynchronous active-high clear of the count |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | 4 | Preset value |
| up_ni | input | 1 | Active-low up count pulse, idle high |
| dn_ni | input | 1 | Active-low down count pulse, idle high |
| q_o | output | 4 | Current count |
| up_term_no | output | 1 | Active-low up terminal pulse (overflow) |
| dn_term_no | output | 1 | Active-low down terminal pulse (underflow) |

## Verification
On every cycle, the assertions check the single-step effect of each qualified count edge, the hold rule, the load rule, the clear override, and that each terminal output is low only while its count input is low. Several behaviours involve sequences or more than one instance, so only the bench scenarios show them: the exact width of the terminal pulses, the asynchronous drop to zero between clock edges, the 8-bit behaviour of the two-stage chain across many wraps in both directions, and the divide ratio for every preset value.

// File: rtl/upc_pkg.sv
package upc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_INC,
    ACT_DEC
  } upc_act_e;
endpackage

// File: rtl/upc_edge_det.sv
// Optional synchronizer followed by a low-to-high transition detector.
// Idle level is high, so every stage resets to 1.
module upc_edge_det #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_ni,
  output logic rise_o
);
  logic lvl;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = pulse_ni;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '1;
        end else begin
          sync_q[0] <= pulse_ni;
          for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign lvl = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/upc_ctrl.sv
// Steering: load beats counting; coincident edges cancel.
module upc_ctrl
  import upc_pkg::*;
(
  input  logic     load_ni,
  input  logic     up_rise_i,
  input  logic     dn_rise_i,
  output upc_act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (!load_ni) begin
      act_o = ACT_LOAD;
    end else begin
      unique case ({up_rise_i, dn_rise_i})
        2'b10:   act_o = ACT_INC;
        2'b01:   act_o = ACT_DEC;
        default: act_o = ACT_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/upc_core.sv
// Count register; clear acts asynchronously and overrides everything.
module upc_core
  import upc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  upc_act_e         act_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    unique case (act_i)
      ACT_LOAD: cnt_d = data_i;
      ACT_INC:  cnt_d = cnt_q + One;
      ACT_DEC:  cnt_d = cnt_q - One;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_d;
  end

  assign q_o = cnt_q;
endmodule

// File: rtl/upc_term.sv
// Terminal outputs gate the raw count pulse, so their width copies it.
module upc_term #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_ni,
  input  logic             dn_ni,
  output logic             up_term_no,
  output logic             dn_term_no
);
  localparam logic [WIDTH-1:0] QMax = '1;

  logic at_max;
  logic at_min;

  assign at_max     = (q_i == QMax);
  assign at_min     = (q_i == '0);
  assign up_term_no = ~(at_max & ~up_ni);
  assign dn_term_no = ~(at_min & ~dn_ni);
endmodule

// File: rtl/updown_pulse_counter.sv
module updown_pulse_counter
  import upc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_ni,
  input  logic             dn_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             up_term_no,
  output logic             dn_term_no
);
  logic     up_rise;
  logic     dn_rise;
  upc_act_e act;
  logic [WIDTH-1:0] cnt;

  upc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_up_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_ni(up_ni),
    .rise_o  (up_rise)
  );

  upc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_dn_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_ni(dn_ni),
    .rise_o  (dn_rise)
  );

  upc_ctrl i_ctrl (
    .load_ni  (load_ni),
    .up_rise_i(up_rise),
    .dn_rise_i(dn_rise),
    .act_o    (act)
  );

  upc_core #(.WIDTH(WIDTH)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .act_i  (act),
    .data_i (data_i),
    .q_o    (cnt)
  );

  upc_term #(.WIDTH(WIDTH)) i_term (
    .q_i       (cnt),
    .up_ni     (up_ni),
    .dn_ni     (dn_ni),
    .up_term_no(up_term_no),
    .dn_term_no(dn_term_no)
  );

  assign q_o = cnt;
endmodule

// File: rtl/upc_checker.sv
// Assumes SYNC_STAGES == 0 (edge seen at the first clock after the rise).
module upc_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             up_ni,
  input logic             dn_ni,
  input logic [WIDTH-1:0] q_o,
  input logic             up_term_no,
  input logic             dn_term_no
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  logic up_prev, dn_prev;
  logic up_rise, dn_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= up_ni;
      dn_prev <= dn_ni;
    end
  end

  assign up_rise = up_ni & ~up_prev;
  assign dn_rise = dn_ni & ~dn_prev;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_rise && !dn_rise && load_ni && !clear_i) |=> (clear_i || $stable(q_o))); // R1

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rise && !dn_rise && load_ni && !clear_i) |=> (clear_i || q_o == $past(q_o) + One)); // R2

  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_rise && !up_rise && load_ni && !clear_i) |=> (clear_i || q_o == $past(q_o) - One)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (q_o == '0)); // R3

  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !clear_i) |=> (clear_i || q_o == $past(data_i))); // R4

  AST_UP_TERM_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_term_no |-> !up_ni); // R5

  AST_DN_TERM_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_term_no |-> !dn_ni); // R6

  AST_BOTH_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rise && dn_rise && load_ni && !clear_i) |=> (clear_i || $stable(q_o))); // R8
endmodule

bind updown_pulse_counter upc_checker #(.WIDTH(WIDTH)) i_upc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .up_ni     (up_ni),
  .dn_ni     (dn_ni),
  .q_o       (q_o),
  .up_term_no(up_term_no),
  .dn_term_no(dn_term_no)
);

// File: tb/test_updown_pulse_counter.sv
`timescale 1ns/1ps
module test_updown_pulse_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] data = 4'd0;
  logic       up_n = 1'b1;
  logic       dn_n = 1'b1;
  logic [3:0] q1, q2;
  logic       ut1, dt1, ut2, dt2;

  int n_chk = 0;
  int n_fail = 0;
  int low_ut, low_dt;
  bit done = 1'b0;

  always #10 clk = ~clk;

  updown_pulse_counter i_updown_pulse_counter (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .load_ni(load_n), .data_i(data),
    .up_ni(up_n), .dn_ni(dn_n), .q_o(q1), .up_term_no(ut1), .dn_term_no(dt1)
  );

  // second stage of the chain
  updown_pulse_counter i_stage2 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .load_ni(1'b1), .data_i(4'd0),
    .up_ni(ut1), .dn_ni(dt1), .q_o(q2), .up_term_no(ut2), .dn_term_no(dt2)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse the selected inputs low for w clock edges, then release; returns
  // after the clock edge that applies the count, sampled mid-cycle.
  task automatic pulse(input bit do_up, input bit do_dn, input int w);
    @(negedge clk);
    if (do_up) up_n = 1'b0;
    if (do_dn) dn_n = 1'b0;
    low_ut = 0;
    low_dt = 0;
    for (int i = 0; i < w; i++) begin
      #1;
      if (!ut1) low_ut++;
      if (!dt1) low_dt++;
      @(negedge clk);
    end
    up_n = 1'b1;
    dn_n = 1'b1;
    #1;
    if (!ut1) low_ut++;
    if (!dt1) low_dt++;
    @(negedge clk);
  endtask

  task automatic load_val(input logic [3:0] v);
    @(negedge clk);
    data = v;
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp8;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset count", q1, 0);
    check("R1 reset up term", ut1, 1);
    check("R1 reset dn term", dt1, 1);
    repeat (4) @(negedge clk);
    check("R1 hold without edges", q1, 0);

    // R4 every preset value
    for (int v = 0; v < 16; v++) begin
      load_val(4'(v));
      check("R4 load value", q1, v);
    end

    // R3 asynchronous clear, overriding load and counting
    load_val(4'd9);
    @(negedge clk);
    clear = 1'b1;
    #1;
    check("R3 clear before clock edge", q1, 0);
    load_n = 1'b0;
    data = 4'd5;
    pulse(1'b1, 1'b0, 2);
    check("R3 clear beats load and count", q1, 0);
    load_n = 1'b1;
    clear = 1'b0;
    @(negedge clk);
    check("R3 still zero after release", q1, 0);
    check("R3 stage two cleared", q2, 0);

    // R9 chained sweep upward with R2/R5 width checks
    exp8 = 0;
    for (int k = 0; k < 300; k++) begin
      w = (k % 3) + 1;
      pulse(1'b1, 1'b0, w);
      exp8 = (exp8 + 1) % 256;
      check("R9 chain value up", {q2, q1}, exp8);
      check("R5 up term width", low_ut, ((exp8 % 16) == 0) ? w : 0);
      check("R6 dn term quiet on up", low_dt, 0);
    end
    check("R2 up wrap count", q1, 300 % 16);

    // R9 chained sweep downward with R2/R6 width checks
    for (int k = 0; k < 300; k++) begin
      int pre;
      pre = exp8;
      w = (k % 4) + 1;
      pulse(1'b0, 1'b1, w);
      exp8 = (exp8 + 255) % 256;
      check("R9 chain value down", {q2, q1}, exp8);
      check("R6 dn term width", low_dt, ((pre % 16) == 0) ? w : 0);
      check("R5 up term quiet on down", low_ut, 0);
    end

    // R2 single-stage wrap in both directions
    load_val(4'd15);
    pulse(1'b1, 1'b0, 1);
    check("R2 15 up gives 0", q1, 0);
    pulse(1'b0, 1'b1, 1);
    check("R2 0 down gives 15", q1, 15);

    // R7 count edge while load is low is discarded
    @(negedge clk);
    data = 4'd6;
    load_n = 1'b0;
    pulse(1'b1, 1'b0, 2);
    pulse(1'b0, 1'b1, 2);
    load_n = 1'b1;
    @(negedge clk);
    check("R7 load wins over count edges", q1, 6);
    repeat (3) @(negedge clk);
    check("R1 hold after load release", q1, 6);

    // R8 coincident edges cancel
    pulse(1'b1, 1'b1, 2);
    check("R8 both edges no change", q1, 6);
    load_val(4'd15);
    pulse(1'b1, 1'b1, 1);
    check("R8 both edges at 15", q1, 15);

    // R10 divide ratio for each preset
    for (int p = 0; p < 16; p++) begin
      int pulses;
      bit seen;
      load_val(4'(p));
      pulses = 0;
      seen = 1'b0;
      while (!seen && pulses < 20) begin
        pulse(1'b1, 1'b0, 1);
        pulses++;
        if (low_ut != 0) seen = 1'b1;
      end
      check("R10 pulses to terminal", pulses, 16 - p);
    end

    do_clear();
    check("R3 final clear", q1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule